// File: doc/BRIEF.md
# Serial Port Modem Control and Loopback Switch

This block holds the modem control byte of a 16550-class serial port and acts on it. The byte drives two active-low handshake pins, keeps one user flag that has no pin, and gates the serial interrupt line. A diagnostic loopback mode turns the port back on itself. In that mode the transmit serial stream feeds the receiver, the transmit pin rests at mark, and the real control pins go inactive. The four control bits stand in for the four modem status inputs, so software can exercise the whole status and interrupt path without a cable.

The block also tracks the four modem status signals, external or looped back, and sets a change flag whenever one moves. A status read returns the current levels together with these flags and clears the flags. Pending changes raise a modem-status interrupt request when the host enables that source. That request is merged with the receive and transmit requests from the rest of the port before the OUT2 gate. The host bus decode, the baud generator and the shift registers sit outside; the block only sees a register strobe with an offset, the transmit shift register output, and the receive shift register input it supplies.

Top module: `uart_modem_ctl`

## Requirements
- R1: After a synchronous reset the control byte reads 0x00, `dtr_n_pad`, `rts_n_pad` and `txd_pad` are 1, and `irq_oe` and `irq_pad` are 0.
- R2: A write at offset 4 stores data bits 4:0. A read at offset 4 returns them in bits 4:0, with bits 7:5 always 0. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: Outside loopback, bit 0 = 1 drives `dtr_n_pad` low and bit 0 = 0 drives it high. Bit 1 controls `rts_n_pad` by the same rule. Each pin follows one clock after the register changes.
- R4: Bit 2 (OUT1) can be written and read back, but outside loopback it changes no pin.
- R5: `irq_oe` follows bit 3 (OUT2). `irq_pad` is 1 only when OUT2 is 1 and an interrupt request is pending, either from `ext_irq_req` or from the modem-status source. With OUT2 = 0, both are 0.
- R6: With bit 4 = 1 (loopback), `txd_pad`, `dtr_n_pad` and `rts_n_pad` are held at 1, and `rsr_in` equals `tsr_out` while `rxd_pad` is ignored. Outside loopback, `rsr_in` equals `rxd_pad` and `txd_pad` follows `tsr_out` one clock later.
- R7: A read at offset 6 returns the status levels, active high: CTS in bit 4, DSR in bit 5, RI in bit 6 and DCD in bit 7. In loopback these are RTS, DTR, OUT1 and OUT2 from the control byte, and the external status pins are ignored.
- R8: A change of CTS, DSR or DCD sets status bit 0, 1 or 3. A fall of RI from 1 to 0 sets bit 2, and a rise of RI does not. A read at offset 6 returns these flags and clears them. Looped-back changes set the flags exactly as pin changes do.
- R9: When `ier_ms` is 1 and any change flag is set, a modem-status interrupt is requested, and this holds in loopback as well. Clearing the flags by a status read withdraws the request.
- R10: Outside loopback, each active-low status pin is resynchronised through SYNC_STAGES flops and shown inverted in the status levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tsr_out | input | 1 | Transmit shift register serial output |
| rsr_in | output | 1 | Receive shift register serial input |
| txd_pad | output | 1 | Transmit pin |
| rxd_pad | input | 1 | Receive pin |
| dtr_n_pad | output | 1 | Data terminal ready, active low |
| rts_n_pad | output | 1 | Request to send, active low |
| cts_n_pad | input | 1 | Clear to send, active low |
| dsr_n_pad | input | 1 | Data set ready, active low |
| ri_n_pad | input | 1 | Ring indicator, active low |
| dcd_n_pad | input | 1 | Carrier detect, active low |
| ier_ms | input | 1 | Modem-status interrupt enable |
| ext_irq_req | input | 1 | Receive/transmit interrupt request from the rest of the port |
| irq_pad | output | 1 | Gated serial interrupt |
| irq_oe | output | 1 | Interrupt pin output enable (low means high impedance) |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, the control byte at offset 4, status at offset 6 and a two-flop status synchroniser. With two stages the path from a status pin to a readable change flag is short and fixed. This lets the bench time a pin edge, the interrupt that follows it, and the read that clears it to the exact cycle. The loopback cases then compare that path against the same flags set by writes alone.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;
  // Control byte, bit 4 down to bit 0.
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;

  // Status levels, active high; packs into status read bits 7:4.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mstat_t;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
  import uart_mcr_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int MCR_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output mcr_t              mcr_q
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(MCR_OFS);

  // Upper data bits are reserved and dropped on write.
  logic unused_hi;
  assign unused_hi = ^wdata[7:5];

  always_ff @(posedge clk) begin
    if (rst)
      mcr_q <= '0;
    else if (wr && addr == SEL)
      mcr_q <= mcr_t'(wdata[4:0]);
  end
endmodule

// File: rtl/modem_sync.sv
module modem_sync
  import uart_mcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] raw_n,   // {dcd, ri, dsr, cts}, active low
  output mstat_t     pin_st
);
  logic [3:0] stg [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 4'hF;
          else     stg[0] <= raw_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= 4'hF;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign pin_st = mstat_t'(~stg[SYNC_STAGES-1]);
endmodule

// File: rtl/lpbk_mux.sv
module lpbk_mux
  import uart_mcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  mcr_t   mcr,
  input  logic   tsr_out,
  input  logic   rxd_pad,
  input  mstat_t pin_st,
  output logic   dtr_n_q,
  output logic   rts_n_q,
  output logic   txd_q,
  output logic   rsr_in,
  output mstat_t st
);
  mstat_t loop_st;

  always_comb begin
    loop_st.cts = mcr.rts;
    loop_st.dsr = mcr.dtr;
    loop_st.ri  = mcr.out1;
    loop_st.dcd = mcr.out2;
  end

  assign st     = mcr.loop ? loop_st : pin_st;
  assign rsr_in = mcr.loop ? tsr_out : rxd_pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n_q <= 1'b1;
      rts_n_q <= 1'b1;
      txd_q   <= 1'b1;
    end else begin
      dtr_n_q <= mcr.loop | ~mcr.dtr;
      rts_n_q <= mcr.loop | ~mcr.rts;
      txd_q   <= mcr.loop | tsr_out;
    end
  end
endmodule

// File: rtl/msr_track.sv
module msr_track
  import uart_mcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mstat_t     st,
  input  logic       clr,
  input  logic       ier_ms,
  output mstat_t     st_q,
  output logic [3:0] delta,    // {ddcd, teri, ddsr, dcts}
  output logic       ms_irq
);
  logic [3:0] new_d;

  always_comb begin
    new_d[0] = st.cts ^ st_q.cts;
    new_d[1] = st.dsr ^ st_q.dsr;
    new_d[2] = st_q.ri & ~st.ri;
    new_d[3] = st.dcd ^ st_q.dcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      delta <= '0;
    end else begin
      st_q  <= st;
      delta <= (clr ? 4'h0 : delta) | new_d;
    end
  end

  assign ms_irq = ier_ms & (|delta);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mcr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int MCR_OFS     = 4,
  parameter int MSR_OFS     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tsr_out,
  output logic              rsr_in,
  output logic              txd_pad,
  input  logic              rxd_pad,
  output logic              dtr_n_pad,
  output logic              rts_n_pad,
  input  logic              cts_n_pad,
  input  logic              dsr_n_pad,
  input  logic              ri_n_pad,
  input  logic              dcd_n_pad,
  input  logic              ier_ms,
  input  logic              ext_irq_req,
  output logic              irq_pad,
  output logic              irq_oe
);
  localparam logic [ADDR_W-1:0] MCR_SEL = ADDR_W'(MCR_OFS);
  localparam logic [ADDR_W-1:0] MSR_SEL = ADDR_W'(MSR_OFS);

  mcr_t       mcr_q;
  mstat_t     pin_st, st, st_q;
  logic [3:0] delta;
  logic       ms_irq;
  logic       msr_rd;
  logic [4:0] mcr_bits;

  assign msr_rd   = bus_rd && bus_addr == MSR_SEL;
  assign mcr_bits = mcr_q;

  mcr_reg #(.ADDR_W(ADDR_W), .MCR_OFS(MCR_OFS)) u_reg (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mcr_q(mcr_q)
  );

  modem_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .raw_n({dcd_n_pad, ri_n_pad, dsr_n_pad, cts_n_pad}),
    .pin_st(pin_st)
  );

  lpbk_mux u_mux (
    .clk(clk), .rst(rst), .mcr(mcr_q), .tsr_out(tsr_out),
    .rxd_pad(rxd_pad), .pin_st(pin_st), .dtr_n_q(dtr_n_pad),
    .rts_n_q(rts_n_pad), .txd_q(txd_pad), .rsr_in(rsr_in), .st(st)
  );

  msr_track u_msr (
    .clk(clk), .rst(rst), .st(st), .clr(msr_rd), .ier_ms(ier_ms),
    .st_q(st_q), .delta(delta), .ms_irq(ms_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_pad   <= 1'b0;
      irq_oe    <= 1'b0;
    end else begin
      irq_oe  <= mcr_q.out2;
      irq_pad <= mcr_q.out2 & (ext_irq_req | ms_irq);
      if (bus_rd) begin
        if (bus_addr == MCR_SEL)      bus_rdata <= {3'b000, mcr_q};
        else if (bus_addr == MSR_SEL) bus_rdata <= {st_q, delta};
        else                          bus_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/uart_mcr_chk.sv
module uart_mcr_chk #(
  parameter int ADDR_W  = 3,
  parameter int MCR_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [4:0]        mcr_bits,
  input logic              dtr_n_pad,
  input logic              rts_n_pad,
  input logic              txd_pad,
  input logic              tsr_out,
  input logic              rsr_in,
  input logic              irq_pad,
  input logic              irq_oe
);
  localparam logic [ADDR_W-1:0] MCR_SEL = ADDR_W'(MCR_OFS);

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == MCR_SEL) |-> bus_rdata[7:5] == 3'b000);

  assert_dtr_pol_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(mcr_bits[4]) |-> dtr_n_pad == !$past(mcr_bits[0]));

  assert_rts_pol_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(mcr_bits[4]) |-> rts_n_pad == !$past(mcr_bits[1]));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(mcr_bits[3]) |-> !irq_pad && !irq_oe);

  assert_pins_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $past(mcr_bits[4]) |-> dtr_n_pad && rts_n_pad && txd_pad);

  assert_serial_loop_R6: assert property (@(posedge clk) disable iff (rst)
    mcr_bits[4] |-> rsr_in == tsr_out);
endmodule

bind uart_modem_ctl uart_mcr_chk #(.ADDR_W(ADDR_W), .MCR_OFS(MCR_OFS)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .mcr_bits(mcr_bits), .dtr_n_pad(dtr_n_pad),
  .rts_n_pad(rts_n_pad), .txd_pad(txd_pad), .tsr_out(tsr_out),
  .rsr_in(rsr_in), .irq_pad(irq_pad), .irq_oe(irq_oe)
);

// File: tb/test_uart_modem_ctl.sv
module test_uart_modem_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MCR = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSR = 3'd6;
  localparam int NVEC = 8;
  // {write byte, expected {dtr_n, rts_n, txd} with tsr_out=0, expected readback}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h00, 3'b110, 8'h00},
    {8'h01, 3'b010, 8'h01},
    {8'h02, 3'b100, 8'h02},
    {8'h03, 3'b000, 8'h03},
    {8'hE7, 3'b000, 8'h07},
    {8'h13, 3'b111, 8'h13},
    {8'hFF, 3'b111, 8'h1F},
    {8'h04, 3'b110, 8'h04}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tsr_out = 0, rsr_in, txd_pad, rxd_pad = 1;
  logic dtr_n_pad, rts_n_pad;
  logic cts_n_pad = 1, dsr_n_pad = 1, ri_n_pad = 1, dcd_n_pad = 1;
  logic ier_ms = 0, ext_irq_req = 0, irq_pad, irq_oe;
  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_ctl i_uart_modem_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tsr_out(tsr_out), .rsr_in(rsr_in), .txd_pad(txd_pad),
    .rxd_pad(rxd_pad), .dtr_n_pad(dtr_n_pad), .rts_n_pad(rts_n_pad),
    .cts_n_pad(cts_n_pad), .dsr_n_pad(dsr_n_pad), .ri_n_pad(ri_n_pad),
    .dcd_n_pad(dcd_n_pad), .ier_ms(ier_ms), .ext_irq_req(ext_irq_req),
    .irq_pad(irq_pad), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    chk("R1 pins", {5'b0, dtr_n_pad, rts_n_pad, txd_pad}, 8'h07);
    chk("R1 irq", {6'b0, irq_oe, irq_pad}, 8'h00);
    rd(A_MCR, rv); chk("R1 mcr", rv, 8'h00);

    // Vector walk: R2 R3 R4 R6
    for (int v = 0; v < NVEC; v++) begin
      wr(A_MCR, VEC[v][18:11]);
      @(negedge clk);
      chk("R3/R4/R6 pins", {5'b0, dtr_n_pad, rts_n_pad, txd_pad}, {5'b0, VEC[v][10:8]});
      rd(A_MCR, rv); chk("R2 readback", rv, VEC[v][7:0]);
    end

    // R6 serial path, normal then loopback
    wr(A_MCR, 8'h00); tsr_out = 1; rxd_pad = 0;
    @(negedge clk);
    chk("R6 normal path", {6'b0, txd_pad, rsr_in}, 8'h02);
    tsr_out = 0; rxd_pad = 1;
    wr(A_MCR, 8'h10); @(negedge clk);
    chk("R6 loop path", {6'b0, txd_pad, rsr_in}, 8'h02);

    // R1 mid-run reset
    wr(A_MCR, 8'h0B); idle(2);
    rst = 1; idle(2); rst = 0;
    chk("R1 reset pins", {5'b0, dtr_n_pad, rts_n_pad, txd_pad}, 8'h07);
    rd(A_MCR, rv); chk("R1 reset mcr", rv, 8'h00);

    // R7 R8 loopback status and change flags
    wr(A_MCR, 8'h10); idle(2);
    rd(A_MSR, rv); chk("R7 loop idle", rv, 8'h00);
    cts_n_pad = 0;
    wr(A_MCR, 8'h1B); idle(4);
    rd(A_MSR, rv); chk("R7/R8 loop set", rv, 8'hBB);
    rd(A_MSR, rv); chk("R8 cleared", rv, 8'hB0);
    wr(A_MCR, 8'h14);
    rd(A_MSR, rv); chk("R8 ri rise", rv, 8'h4B);
    wr(A_MCR, 8'h10);
    rd(A_MSR, rv); chk("R8 teri", rv, 8'h04);

    // R9 interrupt from looped-back change
    ier_ms = 1;
    wr(A_MCR, 8'h19); idle(2);
    chk("R9 loop irq", {6'b0, irq_oe, irq_pad}, 8'h03);
    rd(A_MSR, rv); chk("R9 flags", rv, 8'hAA);
    idle(1);
    chk("R9 irq withdrawn", {6'b0, irq_oe, irq_pad}, 8'h02);

    // R10 leave loopback: external CTS (held low) appears
    wr(A_MCR, 8'h08); idle(4);
    rd(A_MSR, rv); chk("R10 pin status", rv, 8'h1B);
    idle(1);
    chk("R5 oe only", {6'b0, irq_oe, irq_pad}, 8'h02);

    // R5 external request gating
    ext_irq_req = 1; idle(2);
    chk("R5 ext irq", {6'b0, irq_oe, irq_pad}, 8'h03);
    wr(A_MCR, 8'h00); @(negedge clk);
    chk("R5 gated off", {6'b0, irq_oe, irq_pad}, 8'h00);
    ext_irq_req = 0;

    // R10 RI pin fall -> teri, R4 OUT1 no pin
    ri_n_pad = 0; idle(5);
    rd(A_MSR, rv); chk("R10 ri on", rv, 8'h50);
    ri_n_pad = 1; idle(5);
    rd(A_MSR, rv); chk("R8 pin teri", rv, 8'h14);
    wr(A_MCR, 8'h04); @(negedge clk);
    chk("R4 no pin", {5'b0, dtr_n_pad, rts_n_pad, txd_pad}, 8'h06);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule